// File: doc/BRIEF.md
# Factorial Coprocessor Register Unit

This unit is a small memory-mapped coprocessor with a 32-bit register bus on one side and a multi-cycle factorial engine behind it. Software writes an operand n to the argument register. The engine starts at once and sets a busy flag. Software polls that flag until it clears, then reads n! (kept to the low 32 bits) back from the same register. The result replaces the operand in that register.

A status register holds the busy flag and a completion-interrupt enable bit. When a computation ends while that enable is set, the unit sends a single-cycle event with a cause word toward an external interrupt aggregator. The register file also has two other registers. One is a constant identification word. The other is a liveness register that stores the complement of whatever is written to it, which lets software confirm that the bus path works.

Accesses are qualified by a byte-size field. Below offset 0x80, any access that is not a full 4-byte word is dropped. Reads return all ones for such accesses and for any offset that does not map to a register.

Top module: `fact_regunit`

## Requirements
- R1: A 4-byte read at offset 0x00 returns 0x010000ED.
- R2: A 4-byte write at offset 0x04 stores the bitwise complement of the write data, and a 4-byte read at 0x04 returns the stored value.
- R3: A 4-byte write at offset 0x08 while idle loads the operand and sets the busy flag, which is status bit 0 of the word read at offset 0x20.
- R4: A write at offset 0x08 while busy is ignored: the operand in use and the final result are unchanged.
- R5: Busy clears exactly n+1 clock edges after the edge that accepted operand n. From then on a read of 0x08 returns n! modulo 2^32.
- R6: An operand of 0 yields a result of 1, and busy clears one edge after the start.
- R7: A 4-byte write at offset 0x20 copies write-data bit 7 into status bit 7 (the interrupt enable). Write-data bit 0 never sets or clears busy.
- R8: If status bit 7 is set when a computation ends, `evt_valid` is high for exactly one cycle, in the first cycle that busy reads 0, and `evt_cause` is 0x00000001 in that cycle. If bit 7 is clear, no event is sent.
- R9: Below offset 0x80, a read or write whose `bus_size` is not 4 has no effect on any register, and such a read returns 0xFFFFFFFF.
- R10: A read at an offset that maps to no register (any offset other than 0x00, 0x04, 0x08 and 0x20, including every offset from 0x80 up) returns 0xFFFFFFFF.
- R11: After reset, the liveness register, the argument register and the status word all read 0, and `evt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 3 | Access size in bytes (4 means a full word) |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, qualifies `bus_rdata` in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when `bus_rd` is low) |
| evt_valid | output | 1 | One-cycle completion event |
| evt_cause | output | 32 | Cause word carried with the event, zero otherwise |

## Verification
Faults in the engine's down-counter or accumulator show up at the argument register as soon as busy drops, as a wrong product or as a busy flag that clears on the wrong edge. For this reason the bench counts edges from the accepted write to the clearing of busy, and compares both that count and the result for each operand. A lock that leaks while busy shows up as a changed result from a second write made in mid-computation. A wrong enable or event path shows up in the cycle right after completion, as a missing, extra or stretched pulse or a wrong cause word. A decode fault shows up on the very next read as a value other than all ones, or as a register changed by an access it should have dropped.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam logic [7:0] OFF_ID    = 8'h00;
  localparam logic [7:0] OFF_LIVE  = 8'h04;
  localparam logic [7:0] OFF_ARG   = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h20;
  localparam logic [7:0] WIDE_BASE = 8'h80;

  localparam word_t ID_WORD    = 32'h0100_00ED;
  localparam word_t ALL_ONES   = '1;
  localparam word_t CAUSE_DONE = 32'h0000_0001;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_IEN_BIT  = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_LIVE,
    SEL_ARG,
    SEL_STAT
  } regsel_e;

  // one engine step: accumulator times current factor, kept to word width
  function automatic word_t fact_step(word_t acc, word_t factor);
    return acc * factor;
  endfunction

  // status word assembled from its two live bits
  function automatic word_t stat_word(logic busy, logic ien);
    word_t w;
    w = '0;
    w[STAT_BUSY_BIT] = busy;
    w[STAT_IEN_BIT]  = ien;
    return w;
  endfunction
endpackage

// File: rtl/fact_addr_decode.sv
module fact_addr_decode
  import fact_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SIZE_W   = 3,
  parameter int WORD_BYT = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output regsel_e           sel
);
  localparam logic [SIZE_W-1:0] FULL = SIZE_W'(WORD_BYT);

  logic narrow_lo;
  assign narrow_lo = (addr < ADDR_W'(WIDE_BASE)) && (size != FULL);

  always_comb begin
    sel = SEL_NONE;
    if (!narrow_lo) begin
      unique case (addr)
        ADDR_W'(OFF_ID):   sel = SEL_ID;
        ADDR_W'(OFF_LIVE): sel = SEL_LIVE;
        ADDR_W'(OFF_ARG):  sel = SEL_ARG;
        ADDR_W'(OFF_STAT): sel = SEL_STAT;
        default:           sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fact_engine.sv
module fact_engine
  import fact_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  word_t operand,
  output logic  busy,
  output logic  done,
  output word_t result
);
  word_t acc_q;
  word_t cnt_q;
  logic  busy_q;

  assign busy   = busy_q;
  assign done   = busy_q && (cnt_q == '0);
  assign result = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      acc_q  <= word_t'(1);
      cnt_q  <= operand;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        acc_q <= fact_step(acc_q, cnt_q);
        cnt_q <= cnt_q - word_t'(1);
      end
    end
  end
endmodule

// File: rtl/fact_regfile.sv
module fact_regfile
  import fact_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  logic    rd,
  input  regsel_e sel,
  input  word_t   wdata,
  input  logic    busy,
  input  logic    done,
  input  word_t   result,
  output word_t   rdata,
  output logic    start,
  output word_t   op_q,
  output logic    ien_q,
  output logic    evt_q,
  output word_t   cause_q
);
  word_t live_q;

  assign start = wr && (sel == SEL_ARG) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      op_q    <= '0;
      ien_q   <= 1'b0;
      evt_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      if (wr && sel == SEL_LIVE) live_q <= ~wdata;
      if (wr && sel == SEL_STAT) ien_q  <= wdata[STAT_IEN_BIT];
      if (start)     op_q <= wdata;
      else if (done) op_q <= result;
      evt_q   <= done && ien_q;
      cause_q <= (done && ien_q) ? CAUSE_DONE : '0;
    end
  end

  word_t mux;
  always_comb begin
    unique case (sel)
      SEL_ID:   mux = ID_WORD;
      SEL_LIVE: mux = live_q;
      SEL_ARG:  mux = op_q;
      SEL_STAT: mux = stat_word(busy, ien_q);
      default:  mux = ALL_ONES;
    endcase
  end

  assign rdata = rd ? mux : '0;
endmodule

// File: rtl/fact_regunit.sv
module fact_regunit
  import fact_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SIZE_W   = 3,
  parameter int WORD_BYT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SIZE_W-1:0] bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              evt_valid,
  output logic [31:0]       evt_cause
);
  regsel_e sel_w;
  logic    start_w;
  logic    busy_w;
  logic    done_w;
  word_t   result_w;
  word_t   op_q;
  logic    ien_q;

  fact_addr_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WORD_BYT(WORD_BYT)
  ) u_dec (
    .addr(bus_addr), .size(bus_size), .sel(sel_w)
  );

  fact_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_w), .operand(bus_wdata),
    .busy(busy_w), .done(done_w), .result(result_w)
  );

  fact_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .sel(sel_w),
    .wdata(bus_wdata), .busy(busy_w), .done(done_w), .result(result_w),
    .rdata(bus_rdata), .start(start_w), .op_q(op_q), .ien_q(ien_q),
    .evt_q(evt_valid), .cause_q(evt_cause)
  );
endmodule

// File: rtl/fact_regunit_chk.sv
module fact_regunit_chk
  import fact_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SIZE_W-1:0] bus_size,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              evt_valid,
  input logic [31:0]       evt_cause,
  input logic              start_w,
  input logic              busy_w,
  input logic              done_w,
  input logic [31:0]       op_q
);
  assert_busy_from_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_w) |-> $past(start_w));

  assert_arg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !done_w) |=> (op_q == $past(op_q)));

  assert_done_clears_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> !busy_w);

  assert_evt_follows_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(done_w));

  assert_evt_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

  assert_evt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_cause == CAUSE_DONE));

  assert_narrow_read_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr < ADDR_W'(WIDE_BASE) && bus_size != SIZE_W'(4))
      |-> (bus_rdata == ALL_ONES));
endmodule

bind fact_regunit fact_regunit_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .evt_valid(evt_valid),
  .evt_cause(evt_cause), .start_w(start_w), .busy_w(busy_w),
  .done_w(done_w), .op_q(op_q)
);

// File: tb/fact_regunit_tb_top.sv
module fact_regunit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam int NVEC       = 7;
  // operand, interrupt enable for that run
  localparam int unsigned VEC_N  [NVEC] = '{0, 1, 2, 5, 12, 13, 20};
  localparam bit          VEC_IEN[NVEC] = '{1, 0, 1, 0, 1, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = 3'd4;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_valid;
  logic [31:0] evt_cause;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fact_regunit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_valid(evt_valid), .evt_cause(evt_cause)
  );

  function automatic logic [31:0] ref_fact(int unsigned n);
    logic [31:0] r = 32'd1;
    for (int unsigned i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d, logic [2:0] sz);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 3'd4;
  endtask

  task automatic do_read(logic [7:0] a, logic [2:0] sz, output logic [31:0] d);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0; bus_size = 3'd4;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    do_read(8'h04, 3'd4, v); chk("R11 live reset", v, 32'h0);
    do_read(8'h08, 3'd4, v); chk("R11 arg reset", v, 32'h0);
    do_read(8'h20, 3'd4, v); chk("R11 status reset", v, 32'h0);
    chk("R11 evt reset", {31'b0, evt_valid}, 32'h0);

    // R1 identification
    do_read(8'h00, 3'd4, v); chk("R1 id", v, 32'h0100_00ED);

    // R2 liveness complement
    do_write(8'h04, 32'hA5A5_0F0F, 3'd4);
    do_read(8'h04, 3'd4, v); chk("R2 live a", v, 32'h5A5A_F0F0);
    do_write(8'h04, 32'h0000_0000, 3'd4);
    do_read(8'h04, 3'd4, v); chk("R2 live b", v, 32'hFFFF_FFFF);

    // R9 narrow accesses below 0x80
    do_write(8'h04, 32'h1234_5678, 3'd2);
    do_read(8'h04, 3'd4, v); chk("R9 narrow write live", v, 32'hFFFF_FFFF);
    do_read(8'h00, 3'd2, v); chk("R9 narrow read id", v, 32'hFFFF_FFFF);
    do_read(8'h04, 3'd1, v); chk("R9 narrow read live", v, 32'hFFFF_FFFF);
    do_write(8'h08, 32'd3, 3'd1);
    do_read(8'h20, 3'd4, v); chk("R9 narrow arg no start", v, 32'h0);
    do_read(8'h08, 3'd4, v); chk("R9 narrow arg unchanged", v, 32'h0);

    // R10 unmapped offsets
    do_read(8'h10, 3'd4, v); chk("R10 unmapped 0x10", v, 32'hFFFF_FFFF);
    do_read(8'h84, 3'd4, v); chk("R10 unmapped 0x84", v, 32'hFFFF_FFFF);
    do_read(8'hFC, 3'd2, v); chk("R10 unmapped 0xFC", v, 32'hFFFF_FFFF);

    // R7 enable bit, busy bit not writable
    do_write(8'h20, 32'h0000_0080, 3'd4);
    do_read(8'h20, 3'd4, v); chk("R7 ien set", v, 32'h80);
    do_write(8'h20, 32'h0000_0001, 3'd4);
    do_read(8'h20, 3'd4, v); chk("R7 ien clear busy untouched", v, 32'h0);

    // R3 R5 R6 R8 table of operands
    for (int i = 0; i < NVEC; i++) begin
      do_write(8'h20, VEC_IEN[i] ? 32'h80 : 32'h0, 3'd4);
      do_write(8'h08, VEC_N[i], 3'd4);
      k = 0;
      do_read(8'h20, 3'd4, v);
      chk("R3 busy after start", v & 32'h1, 32'h1);
      while (v[0] && k < 100) begin
        chk("R8 no event while busy", {31'b0, evt_valid}, 32'h0);
        @(negedge clk);
        k++;
        do_read(8'h20, 3'd4, v);
      end
      chk(VEC_N[i] == 0 ? "R6 latency zero" : "R5 latency", k, VEC_N[i] + 1);
      chk("R8 event at completion", {31'b0, evt_valid}, {31'b0, VEC_IEN[i]});
      chk("R8 cause", evt_cause, VEC_IEN[i] ? 32'h1 : 32'h0);
      do_read(8'h08, 3'd4, v);
      chk(VEC_N[i] == 0 ? "R6 result of zero" : "R5 result", v, ref_fact(VEC_N[i]));
      @(negedge clk);
      chk("R8 event one cycle", {31'b0, evt_valid}, 32'h0);
    end

    // R4 write while busy ignored
    do_write(8'h08, 32'd6, 3'd4);
    do_write(8'h08, 32'd3, 3'd4);
    k = 0;
    do_read(8'h20, 3'd4, v);
    while (v[0] && k < 100) begin
      @(negedge clk);
      k++;
      do_read(8'h20, 3'd4, v);
    end
    do_read(8'h08, 3'd4, v); chk("R4 locked result", v, ref_fact(6));

    finish_run();
  end
endmodule